// File: doc/BRIEF.md
# Two-Input Buffered Request Merger

This block joins two client request streams into a single stream headed for a shared memory port. It is meant to be one node in a tree of identical mergers, each level narrowing traffic toward the memory. Every side of the block uses a valid/ready handshake, and the payload width is set by a parameter.

Each input feeds a private one-entry holding register. A client's item is captured on the clock edge where valid and ready are both high, and it is offered at the output from the next cycle onward. A register that is being emptied to the output in the current cycle may take a new item in that same cycle, so each input can sustain one item per cycle. An arbiter picks which holding register drives the output. It has three policies, chosen by a static two-bit mode input: fixed priority favouring input A, strict per-cycle alternation, and least-recently-granted order.

Top module: `req_merge2`

## Requirements
- R1: While `rst_ni` is low, both holding registers are empty, `out_valid_o` is 0 and `a_ready_o` is 1. The alternation turn register starts on input A, so `b_ready_o` is 0 in alternation mode and 1 in the other modes. The least-recently-granted history starts so that input A wins the first tie.
- R2: With no contention and `out_ready_i` high, an item accepted on one clock edge appears on `out_data_o` with `out_valid_o` high in the cycle that immediately follows.
- R3: Outside alternation mode, an input's ready is high exactly when its register is empty or its entry is forwarded in that cycle (output valid, output ready, and that register selected). Otherwise it is low.
- R4: In fixed-priority mode, when both registers are full, A's entry is presented and forwarded and B's entry is held.
- R5: Each register has its own path to the output. When only one register is full, its entry is presented in fixed and least-recently-granted modes, whichever input it is.
- R6: In alternation mode a one-bit turn flips on every clock edge after reset (0 selects A, 1 selects B). Only the input whose turn it is may be ready or presented, and `out_valid_o` is low on a turn whose register is empty, even when the other register is full.
- R7: In least-recently-granted mode, when both registers are full, the input not granted by the most recent forward is presented. The history changes only on a cycle with `out_valid_o` and `out_ready_i` both high.
- R8: `out_valid_o` equals the full flag of the register the policy selects. A register empties only on a cycle where `out_ready_i` is high and its entry is the one selected.
- R9: Under random valid and ready patterns in every mode, each accepted item leaves the output exactly once, and items from the same input leave in the order they were accepted.
- R10: `mode_i` encodings are 0 fixed priority, 1 alternation, 2 least-recently-granted, and 3 behaves identically to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Arbitration policy, static while out of reset |
| a_valid_i | input | 1 | Input A item valid |
| a_data_i | input | DATA_W | Input A payload |
| a_ready_o | output | 1 | Input A may hand over an item |
| b_valid_i | input | 1 | Input B item valid |
| b_data_i | input | DATA_W | Input B payload |
| b_ready_o | output | 1 | Input B may hand over an item |
| out_valid_o | output | 1 | Merged output holds an item |
| out_data_o | output | DATA_W | Merged output payload |
| out_ready_i | input | 1 | Downstream takes the item |

## Verification
The bench aims at the cycle where a full register is drained and reloaded at the same time. A design that ignored the drain would stall the input every other cycle. A design that loaded before checking the drain would overwrite an entry that had not left yet, and the per-input sequence check would then see a gap. It fills both registers simultaneously in each mode to catch a wrong tie-break: B winning in fixed mode, or the same input winning twice in a row in least-recently-granted mode. It also sends traffic on one input only in alternation mode, where a design that let the idle input's turn go to the busy one would show up as extra bandwidth and mismatched ready timing. Mode 3 is run in full against the fixed-priority expectations.

// File: rtl/req_merge2_pkg.sv
package req_merge2_pkg;
  typedef enum logic [1:0] {
    ARB_FIXED = 2'd0,
    ARB_ALT   = 2'd1,
    ARB_LRU   = 2'd2,
    ARB_RSVD  = 2'd3
  } arb_mode_e;

  localparam int unsigned NUM_IN = 2;
  localparam logic SRC_A = 1'b0;
  localparam logic SRC_B = 1'b1;
endpackage

// File: rtl/req_merge2_slot.sv
module req_merge2_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              drain_i,
  output logic              in_ready_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  // accept when empty or emptying this cycle
  assign in_ready_o = gate_i & (~full_q | drain_i);
  assign load       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end else if (drain_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R2
  slot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> full_q && (data_q == $past(in_data_i)));

  // R8
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !drain_i) |=> full_q && $stable(data_q));
endmodule

// File: rtl/req_merge2_arb.sv
module req_merge2_arb
  import req_merge2_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  arb_mode_e         mode_i,
  input  logic [NUM_IN-1:0] full_i,
  input  logic              out_ready_i,
  output logic              sel_o,
  output logic              out_valid_o,
  output logic [NUM_IN-1:0] gate_o,
  output logic [NUM_IN-1:0] drain_o
);
  logic turn_q;
  logic hist_q;
  logic fire;

  assign fire = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turn_q <= SRC_A;
      hist_q <= SRC_B;  // A wins first tie
    end else begin
      turn_q <= ~turn_q;
      if (fire) hist_q <= sel_o;
    end
  end

  always_comb begin
    gate_o      = '1;
    sel_o       = ~full_i[SRC_A];
    out_valid_o = |full_i;
    case (mode_i)
      ARB_ALT: begin
        gate_o      = {turn_q, ~turn_q};
        sel_o       = turn_q;
        out_valid_o = full_i[turn_q];
      end
      ARB_LRU: begin
        if (&full_i) sel_o = ~hist_q;
      end
      default: ;
    endcase
  end

  assign drain_o = {fire & sel_o, fire & ~sel_o};

  // R6
  alt_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ARB_ALT) |=> turn_q != $past(turn_q));

  // R4
  fixed_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == ARB_FIXED || mode_i == ARB_RSVD) && (&full_i) && out_ready_i)
      |-> drain_o == 2'b01);

  // R7
  lru_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == ARB_LRU) && (&full_i) && fire) ##1 (&full_i) |-> sel_o != $past(sel_o));
endmodule

// File: rtl/req_merge2.sv
module req_merge2
  import req_merge2_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              a_valid_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic              a_ready_o,
  input  logic              b_valid_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic              b_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  arb_mode_e         mode;
  logic [NUM_IN-1:0] in_valid, in_ready, full, gate, drain;
  logic [DATA_W-1:0] in_data [NUM_IN];
  logic [DATA_W-1:0] buf_data [NUM_IN];
  logic              sel;

  assign mode            = arb_mode_e'(mode_i);
  assign in_valid        = {b_valid_i, a_valid_i};
  assign in_data[SRC_A]  = a_data_i;
  assign in_data[SRC_B]  = b_data_i;
  assign a_ready_o       = in_ready[SRC_A];
  assign b_ready_o       = in_ready[SRC_B];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_slot
    req_merge2_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gate_i     (gate[i]),
      .in_valid_i (in_valid[i]),
      .in_data_i  (in_data[i]),
      .drain_i    (drain[i]),
      .in_ready_o (in_ready[i]),
      .full_o     (full[i]),
      .data_o     (buf_data[i])
    );
  end

  req_merge2_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .full_i      (full),
    .out_ready_i (out_ready_i),
    .sel_o       (sel),
    .out_valid_o (out_valid_o),
    .gate_o      (gate),
    .drain_o     (drain)
  );

  assign out_data_o = buf_data[sel];

  // R8
  out_valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> full[sel]);

  // R3
  ready_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full[SRC_A] && !drain[SRC_A]) |-> !a_ready_o);

  // R8
  no_drain_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_i |=> full == ($past(full) | $past(in_valid & in_ready)));
endmodule

// File: tb/req_merge2_test.sv
`timescale 1ns/1ps
module req_merge2_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          a_valid = 1'b0, b_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic          a_ready, b_ready, out_valid;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  req_merge2 #(.DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .a_valid_i(a_valid), .a_data_i(a_data), .a_ready_o(a_ready),
    .b_valid_i(b_valid), .b_data_i(b_data), .b_ready_o(b_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit            m_fa, m_fb, m_turn, m_hist;
  logic [DW-1:0] m_da, m_db;
  int unsigned   seq_a, seq_b, exp_a, exp_b;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string sel_req(input logic [1:0] md);
    case (md)
      2'd1: return "R6";
      2'd2: return "R7";
      2'd3: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic do_reset(input logic [1:0] md);
    @(negedge clk);
    rst_ni = 1'b0; mode = md;
    a_valid = 1'b0; b_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", DW'(out_valid), 0);
    chk(a_ready == 1'b1, "R1", "a_ready in reset", DW'(a_ready), 1);
    chk(b_ready == (md != 2'd1), "R1", "b_ready in reset", DW'(b_ready), DW'(md != 2'd1));
    @(negedge clk);
    rst_ni = 1'b1;
    m_fa = 0; m_fb = 0; m_turn = 0; m_hist = 1; m_da = '0; m_db = '0;
    seq_a = 0; seq_b = 0; exp_a = 0; exp_b = 0;
  endtask

  // one cycle: drive at negedge, compare 1 ns later, advance model
  task automatic cycle(input bit av, input bit bv, input bit ordy, input string ctx);
    bit alt, lru, sel, ov, ga, gb, gr_a, gr_b, ar, br;
    string rdy_req;
    a_valid = av; b_valid = bv; out_ready = ordy;
    a_data = {1'b0, seq_a[30:0]};
    b_data = {1'b1, seq_b[30:0]};
    #1;
    alt = (mode == 2'd1);
    lru = (mode == 2'd2);
    ga = alt ? ~m_turn : 1'b1;
    gb = alt ? m_turn : 1'b1;
    if (alt) begin
      sel = m_turn; ov = m_turn ? m_fb : m_fa;
    end else begin
      sel = (lru && m_fa && m_fb) ? ~m_hist : ~m_fa;
      ov = m_fa | m_fb;
    end
    gr_a = ov & ordy & ~sel;
    gr_b = ov & ordy & sel;
    ar = ga & (~m_fa | gr_a);
    br = gb & (~m_fb | gr_b);
    rdy_req = alt ? "R6" : "R3";
    chk(out_valid == ov, "R8", {"out_valid ", ctx}, DW'(out_valid), DW'(ov));
    chk(a_ready == ar, rdy_req, {"a_ready ", ctx}, DW'(a_ready), DW'(ar));
    chk(b_ready == br, rdy_req, {"b_ready ", ctx}, DW'(b_ready), DW'(br));
    if (ov)
      chk(out_data == (sel ? m_db : m_da), sel_req(mode), {"out_data ", ctx},
          out_data, sel ? m_db : m_da);
    // R9: per-input order, no loss or duplicate
    if (out_valid && out_ready) begin
      if (out_data[DW-1] == 1'b0) begin
        chk(out_data[30:0] == exp_a[30:0], "R9", "A sequence", out_data, DW'(exp_a));
        exp_a++;
      end else begin
        chk(out_data[30:0] == exp_b[30:0], "R9", "B sequence", out_data, {1'b1, exp_b[30:0]});
        exp_b++;
      end
    end
    if (av && a_ready) seq_a++;
    if (bv && b_ready) seq_b++;
    if (av && ar) begin m_fa = 1; m_da = a_data; end
    else if (gr_a) m_fa = 0;
    if (bv && br) begin m_fb = 1; m_db = b_data; end
    else if (gr_b) m_fb = 0;
    if (ov && ordy) m_hist = sel;
    m_turn = ~m_turn;
    @(negedge clk);
  endtask

  task automatic drain_and_count(input string tag);
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, 1'b1, "drain");
    chk(exp_a == seq_a, "R9", {"A delivered count ", tag}, DW'(exp_a), DW'(seq_a));
    chk(exp_b == seq_b, "R9", {"B delivered count ", tag}, DW'(exp_b), DW'(seq_b));
  endtask

  task automatic random_run(input int n, input int pa, input int pb, input int pr);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 100) < pa, ($urandom % 100) < pb, ($urandom % 100) < pr, "random R9");
  endtask

  initial begin
    void'($urandom(32'h5eed));

    // fixed priority
    do_reset(2'd0);
    cycle(1, 0, 1, "R2 accept A");
    cycle(0, 0, 1, "R2 A one cycle later");
    cycle(1, 1, 0, "R4 fill both");
    cycle(0, 0, 0, "R4 both held");
    cycle(0, 0, 1, "R4 A first");
    cycle(0, 0, 1, "R5 B alone");
    cycle(0, 1, 1, "R5 accept B");
    cycle(1, 1, 1, "R3 accept while draining");
    for (int i = 0; i < 6; i++) cycle(1, 1, 1, "R3 streaming");
    drain_and_count("fixed");
    random_run(3000, 60, 60, 70);
    drain_and_count("fixed random");

    // alternation
    do_reset(2'd1);
    for (int i = 0; i < 12; i++) cycle(1, 0, 1, "R6 A only");
    drain_and_count("alt single");
    for (int i = 0; i < 12; i++) cycle(1, 1, 1, "R6 both");
    drain_and_count("alt both");
    random_run(3000, 60, 60, 70);
    drain_and_count("alt random");

    // least recently granted
    do_reset(2'd2);
    cycle(1, 1, 0, "R7 fill both");
    cycle(0, 0, 1, "R7 A first after reset");
    cycle(1, 0, 0, "R7 refill A");
    cycle(0, 0, 0, "R7 history held without forward");
    cycle(0, 0, 1, "R7 B now");
    cycle(0, 1, 1, "R7 A then");
    for (int i = 0; i < 8; i++) cycle(1, 1, 1, "R7 alternate under load");
    drain_and_count("lru");
    random_run(3000, 60, 60, 70);
    drain_and_count("lru random");

    // reserved code behaves as fixed
    do_reset(2'd3);
    cycle(1, 1, 0, "R10 fill both");
    cycle(0, 0, 1, "R10 A first");
    random_run(2000, 70, 70, 60);
    drain_and_count("rsvd random");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule